// File: doc/BRIEF.md
# Next-PC and Branch Resolver

This unit decides the next fetch address for a 32-bit in-order core that has one branch delay slot. In every cycle the core presents the address and the decoded fields of the instruction now executing, along with the two source register values. The unit sorts the instruction into one of four address sources, tests the branch condition, and forms the jump target, the branch target and the return address. A branch or jump that is taken does not redirect the very next fetch. The instruction that follows it, the delay slot, is fetched first. The target is presented one cycle later from a small pending register.

Link-type instructions report a register-file write of the return address, which is the address after the delay slot. The unit only reports the write; the core performs it. When a register jump lands on address zero, the unit raises a halt flag, which is how a program signals that it has finished. After reset, the first address the unit hands out is the boot vector.

Top module: `npc_resolver`

## Requirements
- R1: In the first cycle after rst_ni is released, next_pc_o equals RESET_VEC (default 0xBFC00000). In that same cycle src_sel_o is 0, and both link_we_o and halt_o are low.
- R2: For an instruction that does not transfer control, src_sel_o is 0. When no transfer is pending, next_pc_o is pc_i+4.
- R3: For a taken conditional branch, src_sel_o is 1 and the current next_pc_o is unchanged. In the following cycle (the delay slot), next_pc_o equals the branch's pc+4 plus offset_i sign-extended and shifted left by 2.
- R4: The opcode_i values 4, 5, 6 and 7 branch under these conditions:
  - 4: rs equals rt.
  - 5: rs differs from rt.
  - 6: signed rs is less than or equal to 0.
  - 7: signed rs is greater than 0.
- R5: opcode_i 1 selects a sign test on rs by rt_i:
  - rt_i 0 and 16 branch when rs is negative.
  - rt_i 1 and 17 branch when rs is non-negative.
  - Any other rt_i value transfers nothing.
- R6: opcode_i 2 and 3 always jump, with src_sel_o 2. The target, applied after the delay slot, is bits 31:28 of pc+4, then target_i, then two zero bits.
- R7: A register jump (src_sel_o 3, target rs) happens only when opcode_i is 0 and funct_i is 8 or 9. The same funct values under any other opcode have no effect.
- R8: For opcode_i 3, and for opcode_i 1 with rt_i 16 or 17, link_we_o is high with link_idx_o 31. The opcode_i 1 forms write the link whether or not they branch. For opcode_i 0 with funct_i 9, the link goes to rd_i. In all link cases link_val_o is pc_i+8.
- R9: A register jump with link whose rd_i is 0 does not assert link_we_o.
- R10: In the delay-slot cycle after a register jump whose target is 0, halt_o is high and next_pc_o is 0. At any other time halt_o is low.
- R11: A taken transfer in a delay slot sets the address for the cycle after that slot. The earlier transfer's target is still used for the delay slot itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the executing instruction |
| opcode_i | input | 6 | Primary opcode field |
| rt_i | input | 5 | rt field (selects the sign test under opcode 1) |
| rd_i | input | 5 | rd field (link destination for a register jump with link) |
| funct_i | input | 6 | Function field under opcode 0 |
| offset_i | input | 16 | Branch word offset |
| target_i | input | 26 | Jump word index |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| next_pc_o | output | 32 | Address to fetch next |
| src_sel_o | output | 2 | Source taken now: 0 sequential, 1 branch, 2 region jump, 3 register jump |
| link_we_o | output | 1 | Return address write request |
| link_idx_o | output | 5 | Destination register of the link write |
| link_val_o | output | 32 | Return address (pc_i+8) |
| halt_o | output | 1 | Program end: register jump to address 0 |

## Verification
The state that matters is the pending target and its flag. If either is wrong, the error shows in next_pc_o exactly one cycle after the transfer. The fetch either fails to leave the sequential path or leaves it one slot too early or too late. A wrong condition or decode shows in the same cycle on src_sel_o and the link outputs. The reference model steps a fetch address through the same sequence as the design, so a single wrong address is caught at its own cycle and is not hidden by the addresses after it. The cases that stress the pending logic are backward offsets, transfers placed back to back in delay slots, and a link whose branch is not taken.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 32;
  localparam int REG_W = 5;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_JMP     = 6'd2;
  localparam logic [5:0] OP_JMPL    = 6'd3;
  localparam logic [5:0] OP_BR_EQ   = 6'd4;
  localparam logic [5:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0] OP_BR_LEZ  = 6'd6;
  localparam logic [5:0] OP_BR_GTZ  = 6'd7;

  localparam logic [5:0] FN_RJMP    = 6'd8;
  localparam logic [5:0] FN_RJMPL   = 6'd9;

  localparam logic [4:0] RI_LTZ     = 5'd0;
  localparam logic [4:0] RI_GEZ     = 5'd1;
  localparam logic [4:0] RI_LTZL    = 5'd16;
  localparam logic [4:0] RI_GEZL    = 5'd17;

  localparam logic [4:0] LINK_REG   = 5'd31;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_REGION = 2'd2,
    SRC_REG    = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    C_NEVER, C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ, C_ALWAYS
  } cond_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [5:0]       opcode_i,
  input  logic [4:0]       rt_i,
  input  logic [4:0]       rd_i,
  input  logic [5:0]       funct_i,
  output cond_e            cond_o,
  output src_e             kind_o,
  output logic             link_en_o,
  output logic [REG_W-1:0] link_idx_o
);
  always_comb begin
    cond_o     = C_NEVER;
    kind_o     = SRC_SEQ;
    link_en_o  = 1'b0;
    link_idx_o = '0;
    case (opcode_i)
      OP_SPECIAL: begin
        if (funct_i == FN_RJMP || funct_i == FN_RJMPL) begin
          cond_o = C_ALWAYS;
          kind_o = SRC_REG;
          // register 0 is never written
          if (funct_i == FN_RJMPL && rd_i != '0) begin
            link_en_o  = 1'b1;
            link_idx_o = rd_i;
          end
        end
      end
      OP_REGIMM: begin
        kind_o = SRC_BRANCH;
        case (rt_i)
          RI_LTZ:  cond_o = C_LTZ;
          RI_GEZ:  cond_o = C_GEZ;
          RI_LTZL: begin cond_o = C_LTZ; link_en_o = 1'b1; link_idx_o = LINK_REG; end
          RI_GEZL: begin cond_o = C_GEZ; link_en_o = 1'b1; link_idx_o = LINK_REG; end
          default: begin cond_o = C_NEVER; kind_o = SRC_SEQ; end
        endcase
      end
      OP_JMP:    begin cond_o = C_ALWAYS; kind_o = SRC_REGION; end
      OP_JMPL: begin
        cond_o     = C_ALWAYS;
        kind_o     = SRC_REGION;
        link_en_o  = 1'b1;
        link_idx_o = LINK_REG;
      end
      OP_BR_EQ:  begin cond_o = C_EQ;  kind_o = SRC_BRANCH; end
      OP_BR_NE:  begin cond_o = C_NE;  kind_o = SRC_BRANCH; end
      OP_BR_LEZ: begin cond_o = C_LEZ; kind_o = SRC_BRANCH; end
      OP_BR_GTZ: begin cond_o = C_GTZ; kind_o = SRC_BRANCH; end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  cond_e            cond_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic             pass_o
);
  logic neg, zero, same;
  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);
  assign same = (rs_i == rt_i);

  always_comb begin
    case (cond_i)
      C_EQ:     pass_o = same;
      C_NE:     pass_o = !same;
      C_LEZ:    pass_o = neg | zero;
      C_GTZ:    pass_o = !neg & !zero;
      C_LTZ:    pass_o = neg;
      C_GEZ:    pass_o = !neg;
      C_ALWAYS: pass_o = 1'b1;
      default:  pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] index_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  branch_o,
  output logic [XLEN-1:0]  region_o,
  output logic [XLEN-1:0]  ret_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int HI_W  = XLEN - IDX_W - 2;

  logic [XLEN-1:0] off_bytes;
  assign off_bytes = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
  assign seq_o     = pc_i + XLEN'(4);
  assign ret_o     = pc_i + XLEN'(8);
  // both targets are relative to the delay-slot address
  assign branch_o  = seq_o + off_bytes;
  assign region_o  = {seq_o[XLEN-1 -: HI_W], index_i, 2'b00};
endmodule

// File: rtl/npc_resolver.sv
module npc_resolver
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] pc_i,
  input  logic [5:0]  opcode_i,
  input  logic [4:0]  rt_i,
  input  logic [4:0]  rd_i,
  input  logic [5:0]  funct_i,
  input  logic [15:0] offset_i,
  input  logic [25:0] target_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic [1:0]  src_sel_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_val_o,
  output logic        halt_o
);
  cond_e           cond;
  src_e            kind, src;
  logic            pass, link_en;
  logic [4:0]      link_idx;
  logic [31:0]     seq, br_tgt, rg_tgt, ret, chosen;

  logic            boot_q, pend_q, pend_reg_q;
  logic [31:0]     pend_tgt_q;

  npc_decode u_dec (
    .opcode_i, .rt_i, .rd_i, .funct_i,
    .cond_o(cond), .kind_o(kind), .link_en_o(link_en), .link_idx_o(link_idx)
  );

  npc_cond u_cond (.cond_i(cond), .rs_i(rs_val_i), .rt_i(rt_val_i), .pass_o(pass));

  npc_target #(.OFF_W(16), .IDX_W(26)) u_tgt (
    .pc_i, .offset_i, .index_i(target_i),
    .seq_o(seq), .branch_o(br_tgt), .region_o(rg_tgt), .ret_o(ret)
  );

  assign src = (pass && !boot_q) ? kind : SRC_SEQ;

  always_comb begin
    case (src)
      SRC_BRANCH: chosen = br_tgt;
      SRC_REGION: chosen = rg_tgt;
      SRC_REG:    chosen = rs_val_i;
      default:    chosen = seq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q     <= 1'b1;
      pend_q     <= 1'b0;
      pend_reg_q <= 1'b0;
      pend_tgt_q <= '0;
    end else begin
      boot_q     <= 1'b0;
      pend_q     <= (src != SRC_SEQ);
      pend_reg_q <= (src == SRC_REG);
      pend_tgt_q <= chosen;
    end
  end

  assign next_pc_o  = boot_q ? RESET_VEC : (pend_q ? pend_tgt_q : seq);
  assign src_sel_o  = src;
  assign link_we_o  = link_en && !boot_q;
  assign link_idx_o = link_idx;
  assign link_val_o = ret;
  assign halt_o     = pend_q && pend_reg_q && (pend_tgt_q == '0);
endmodule

// File: rtl/npc_resolver_chk.sv
module npc_resolver_chk #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [5:0]  opcode_i,
  input logic [15:0] offset_i,
  input logic [25:0] target_i,
  input logic [31:0] next_pc_o,
  input logic [1:0]  src_sel_o,
  input logic        link_we_o,
  input logic [4:0]  link_idx_o,
  input logic [31:0] link_val_o,
  input logic        halt_o
);
  logic        first_q;
  logic [31:0] off_bytes;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) first_q <= 1'b1;
    else         first_q <= 1'b0;

  assign off_bytes = {{14{offset_i[15]}}, offset_i, 2'b00};

  a_r1_boot_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (next_pc_o == RESET_VEC && !link_we_o && !halt_o));

  a_r2_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_q && src_sel_o == 2'd0) |=> (next_pc_o == pc_i + 32'd4));

  a_r3_branch_after_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o == 2'd1) |=> (next_pc_o == $past(pc_i) + 32'd4 + $past(off_bytes)));

  a_r6_region_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o == 2'd2) |=>
      (next_pc_o == {$past(pc_i + 32'd4) >> 28, $past(target_i), 2'b00}));

  a_r7_reg_jump_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o == 2'd3) |-> (opcode_i == 6'd0));

  a_r8_return_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_val_o == pc_i + 32'd8));

  a_r9_no_zero_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_idx_o != 5'd0));

  a_r10_halt_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (next_pc_o == 32'd0 && $past(src_sel_o) == 2'd3));
endmodule

bind npc_resolver npc_resolver_chk #(.RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/sim_npc_resolver.sv
module sim_npc_resolver;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  opcode_i = '0, funct_i = '0;
  logic [4:0]  rt_i = '0, rd_i = '0;
  logic [15:0] offset_i = '0;
  logic [25:0] target_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic [31:0] next_pc_o, link_val_o;
  logic [1:0]  src_sel_o;
  logic        link_we_o, halt_o;
  logic [4:0]  link_idx_o;

  int checks = 0, fails = 0;

  bit          m_boot = 1'b1, m_pend = 1'b0, m_pend_reg = 1'b0;
  logic [31:0] m_pc = '0, m_tgt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_resolver u0 (
    .clk_i(clk), .rst_ni, .pc_i, .opcode_i, .rt_i, .rd_i, .funct_i,
    .offset_i, .target_i, .rs_val_i, .rt_val_i,
    .next_pc_o, .src_sel_o, .link_we_o, .link_idx_o, .link_val_o, .halt_o
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(string tag, logic [5:0] op, logic [4:0] rt, logic [4:0] rd,
                      logic [5:0] fn, logic [15:0] off, logic [25:0] tg,
                      logic [31:0] a, logic [31:0] b);
    int          sel;
    bit          take, we, halt;
    logic [4:0]  idx;
    logic [31:0] tgt, nxt, pc4;
    pc_i = m_pc; opcode_i = op; rt_i = rt; rd_i = rd; funct_i = fn;
    offset_i = off; target_i = tg; rs_val_i = a; rt_val_i = b;
    #1;
    pc4 = m_pc + 32'd4;
    sel = 0; take = 0; we = 0; idx = 0; tgt = pc4;
    if (op == 0 && (fn == 8 || fn == 9)) begin
      sel = 3; take = 1; tgt = a;
      if (fn == 9 && rd != 0) begin we = 1; idx = rd; end
    end else if (op == 1 && (rt == 0 || rt == 1 || rt == 16 || rt == 17)) begin
      take = (rt == 0 || rt == 16) ? ($signed(a) < 0) : ($signed(a) >= 0);
      if (rt >= 16) begin we = 1; idx = 31; end
    end else if (op == 2 || op == 3) begin
      sel = 2; take = 1; tgt = {pc4[31:28], tg, 2'b00};
      if (op == 3) begin we = 1; idx = 31; end
    end else if (op >= 4 && op <= 7) begin
      case (op)
        4: take = (a == b);
        5: take = (a != b);
        6: take = ($signed(a) <= 0);
        default: take = ($signed(a) > 0);
      endcase
    end
    if (sel == 0 && take) begin
      sel = 1;
      tgt = pc4 + (32'($signed(off)) <<< 2);
    end
    if (!take) sel = 0;
    if (m_boot) begin
      nxt = BOOT; sel = 0; we = 0; halt = 0;
    end else begin
      nxt  = m_pend ? m_tgt : pc4;
      halt = m_pend && m_pend_reg && (m_tgt == 0);
    end
    checks++;
    if (next_pc_o !== nxt || src_sel_o !== 2'(sel) || link_we_o !== we ||
        halt_o !== halt || (we && (link_idx_o !== idx || link_val_o !== m_pc + 32'd8))) begin
      fails++;
      $display("FAIL %s pc=%h: got next=%h sel=%0d we=%b idx=%0d val=%h halt=%b, exp next=%h sel=%0d we=%b idx=%0d val=%h halt=%b",
               tag, m_pc, next_pc_o, src_sel_o, link_we_o, link_idx_o, link_val_o, halt_o,
               nxt, sel, we, idx, m_pc + 32'd8, halt);
    end
    @(posedge clk);
    m_pend     = !m_boot && sel != 0;
    m_pend_reg = !m_boot && sel == 3;
    m_tgt      = tgt;
    m_boot     = 0;
    m_pc       = nxt;
    @(negedge clk);
  endtask

  task automatic nop(string tag);
    step(tag, 6'd0, 5'd0, 5'd0, 6'd0, 16'd0, 26'd0, 32'd0, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    nop("R1");                                        // boot vector
    nop("R2");
    step("R4", 4, 0, 0, 0, 16'd3, 0, 32'd5, 32'd5);   // equal, taken
    nop("R3");                                        // delay slot
    nop("R3");                                        // at branch target
    step("R4", 4, 0, 0, 0, 16'd3, 0, 32'd3, 32'd5);   // equal, not taken
    nop("R4");
    step("R4", 5, 0, 0, 0, 16'd2, 0, 32'd3, 32'd5);   // not-equal, taken
    nop("R4");
    step("R4", 6, 0, 0, 0, 16'd4, 0, 32'hFFFF0000, 0); // <=0 on negative
    nop("R4");
    step("R4", 7, 0, 0, 0, 16'd4, 0, 32'd0, 0);        // >0 on zero: no
    step("R4", 7, 0, 0, 0, 16'd4, 0, 32'd5, 0);
    nop("R4");
    step("R5", 1, 0, 0, 0, 16'd5, 0, 32'hFFFF0000, 0); // <0
    nop("R5");
    step("R5", 1, 1, 0, 0, 16'd5, 0, 32'd0, 0);        // >=0 on zero
    nop("R5");
    step("R5", 1, 1, 0, 0, 16'd5, 0, 32'h80000000, 0); // >=0 on min: no
    step("R5", 1, 2, 0, 0, 16'd5, 0, 32'hFFFFFFFF, 0); // unknown rt
    nop("R5");
    step("R3", 4, 0, 0, 0, 16'hFFFE, 0, 32'd7, 32'd7); // backward
    nop("R3");
    nop("R3");
    step("R6", 2, 0, 0, 0, 0, 26'h123456, 0, 0);
    nop("R6");
    step("R8", 3, 0, 0, 0, 0, 26'h0000040, 0, 0);
    nop("R8");
    step("R8", 1, 16, 0, 0, 16'd3, 0, 32'd1, 0);       // link, not taken
    nop("R8");
    step("R8", 0, 0, 5'd4, 6'd9, 0, 0, 32'hBFC00100, 0);
    nop("R8");
    step("R9", 0, 0, 5'd0, 6'd9, 0, 0, 32'hBFC00200, 0);
    nop("R9");
    step("R7", 6'h0F, 0, 5'd4, 6'd8, 0, 0, 32'd0, 0);  // funct 8 elsewhere
    nop("R7");
    step("R11", 4, 0, 0, 0, 16'd8, 0, 32'd1, 32'd1);
    step("R11", 5, 0, 0, 0, 16'd20, 0, 32'd1, 32'd2);  // in the slot
    nop("R11");
    nop("R11");
    step("R10", 0, 0, 0, 6'd8, 0, 0, 32'd0, 0);        // jump to zero
    nop("R10");                                        // halt here
    nop("R10");                                        // halt gone
    finish_run();
  end
endmodule